// File: doc/BRIEF.md
# Dual-Read Register File with Zero Register

This block holds the general-purpose registers of a single-cycle RISC core. There are thirty-two 32-bit entries. Two read ports work independently and combinationally: each takes a 5-bit index and returns that entry's contents in the same cycle, with no clock involved. One write port takes an index, a data word and an enable. It updates storage on the rising clock edge.

Index 31 is a constant zero. Reads of it return zero on both ports. A write aimed at it is dropped, so no storage exists behind it.

There is no forwarding from the write port to the reads. During a cycle in which an entry is being written, a read of that entry still returns the value from before the edge. The new value can be read once the edge has passed. A synchronous active-high reset clears every entry to zero.

Top module: `dual_read_regfile`

## Requirements
- R1: The file has 32 entries of 32 bits, selected by 5-bit indices. A write to one entry leaves every other entry unchanged.
- R2: When `wr_en` is high at a rising clock edge, the entry at `wr_addr` takes `wr_data`. It reads back with that value after the edge.
- R3: When `wr_en` is low at an edge, no entry changes, whatever values `wr_addr` and `wr_data` carry.
- R4: Reading index 31 (all ones) on either port returns 32'h0.
- R5: A write with `wr_addr` equal to 31 is discarded. Index 31 still reads zero afterwards, and no other entry changes.
- R6: When `wr_en` is high and a read index equals `wr_addr`, that read port returns the entry's old contents until the edge. It returns the new contents after the edge. This applies on both ports.
- R7: Each read port follows its own index combinationally within a cycle. Port A and port B may read different entries at the same time.
- R8: With `rst` high at a rising edge, every entry becomes zero. This takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| rd_addr_a | input | 5 | Read index, port A |
| rd_data_a | output | 32 | Read data, port A (combinational) |
| rd_addr_b | input | 5 | Read index, port B |
| rd_data_b | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write index |
| wr_data | input | 32 | Write data |

## Verification
The hardest case to observe from the ports is the cycle in which an entry is both being written and being read. In that cycle the output must still show the old value. It must switch to the new value only after the edge, and one sample taken at the wrong moment would hide the difference.

The bench drives the matching read and write index together on both ports for every index, including 31. It compares the output in the low phase before the edge against the old contents held in its reference array. It compares again in the low phase after the edge against the written value, which is the bitwise complement of the old one.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int NUM_REGS = 32;
    parameter int DATA_W   = 32;
    parameter int NUM_RD   = 2;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int ZERO_IDX = NUM_REGS - 1;

    typedef logic [ADDR_W-1:0]                addr_t;
    typedef logic [DATA_W-1:0]                word_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0]  bank_t;
    typedef logic [NUM_REGS-1:0]              sel_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    function automatic logic is_zero_idx(input addr_t a);
        return a == addr_t'(ZERO_IDX);
    endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
    import rf_pkg::*;
(
    input  wr_req_t req,
    output sel_t    sel
);
    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (req.en && (req.addr == addr_t'(k)) && (k != ZERO_IDX))
                sel[k] = 1'b1;
        end
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sel_t  sel,
    input  word_t wdata,
    output bank_t bank
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        if (i == ZERO_IDX) begin : g_zero
            assign bank[i] = '0;
        end else begin : g_reg
            word_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (sel[i])
                    q <= wdata;
            end
            assign bank[i] = q;
        end
    end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
    import rf_pkg::*;
(
    input  bank_t bank,
    input  addr_t addr,
    output word_t data
);
    always_comb begin
        if (is_zero_idx(addr))
            data = '0;
        else
            data = bank[addr];
    end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile
    import rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_addr_a,
    output logic [31:0] rd_data_a,
    input  logic [4:0]  rd_addr_b,
    output logic [31:0] rd_data_b,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [31:0] wr_data
);
    wr_req_t req;
    sel_t    sel;
    bank_t   bank;
    addr_t   rd_addr [NUM_RD];
    word_t   rd_data [NUM_RD];

    assign req.en   = wr_en;
    assign req.addr = wr_addr;
    assign req.data = wr_data;

    rf_wr_decode u_dec (
        .req (req),
        .sel (sel)
    );

    rf_storage u_store (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .wdata (req.data),
        .bank  (bank)
    );

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_rd_port u_port (
            .bank (bank),
            .addr (rd_addr[p]),
            .data (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rd_addr_a,
    input logic [31:0] rd_data_a,
    input logic [4:0]  rd_addr_b,
    input logic [31:0] rd_data_b,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [31:0] wr_data
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_zero_reg_a_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == 5'd31) |-> (rd_data_a == 32'h0));
    assert_zero_reg_b_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == 5'd31) |-> (rd_data_b == 32'h0));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr_en) && ($past(wr_addr) != 5'd31) && (rd_addr_a == $past(wr_addr)))
        |-> (rd_data_a == $past(wr_data)));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(wr_en) && (rd_addr_b == $past(rd_addr_b)))
        |-> (rd_data_b == $past(rd_data_b)));

    assert_old_value_a_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && wr_en && (wr_addr == rd_addr_a) && (wr_data != rd_data_a))
        |=> (rd_data_a != $past(rd_data_a)) || ($past(wr_addr) == 5'd31));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> ((rd_data_a == 32'h0) && (rd_data_b == 32'h0)));
endmodule

bind dual_read_regfile rf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/dual_read_regfile_tb.sv
module dual_read_regfile_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en;

    logic [31:0] model [32];
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dual_read_regfile u_dut (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int i, input int salt);
        return (32'h5A00_00C3 ^ (32'(i) * 32'h0101_0101)) + 32'(salt) * 32'h0001_0007;
    endfunction

    // read sweep: port A ascending, port B descending
    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            @(posedge clk); #1;
            rd_addr_a = 5'(i);
            rd_addr_b = 5'(31 - i);
            @(negedge clk);
            check(req, rd_data_a, model[i]);
            check(req, rd_data_b, model[31 - i]);
        end
    endtask

    task automatic write(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(posedge clk);
        if (a != 31) model[a] = d;
        #1 wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        wr_en = 1'b1; wr_addr = 5'd3; wr_data = 32'hDEAD_BEEF;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8: reset state
        sweep("R8 reset state");

        // R1 R2 R4 R5: fill every entry, including a write to index 31
        for (int i = 0; i < 32; i++) write(i, pattern(i, 1));
        write(31, 32'hFFFF_FFFF);
        sweep("R1 R2 R4 R5 fill and read");

        // R1: overwrite a single entry, others untouched
        write(17, 32'h1234_5678);
        sweep("R1 single entry update");

        // R3: enable low with toggling address and data
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b0; wr_addr = 5'(i * 7); wr_data = ~pattern(i, 9);
        end
        sweep("R3 disabled writes");

        // R6: same-cycle write and read of the same index on both ports
        for (int i = 0; i < 32; i++) begin
            logic [31:0] oldv, newv;
            oldv = model[i];
            newv = ~oldv;
            @(posedge clk); #1;
            wr_en = 1'b1; wr_addr = 5'(i); wr_data = newv;
            rd_addr_a = 5'(i); rd_addr_b = 5'(i);
            @(negedge clk);
            check("R6 port A before edge", rd_data_a, oldv);
            check("R6 port B before edge", rd_data_b, oldv);
            @(posedge clk);
            if (i != 31) model[i] = newv;
            #1 wr_en = 1'b0;
            @(negedge clk);
            check("R6 port A after edge", rd_data_a, model[i]);
            check("R6 port B after edge", rd_data_b, model[i]);
        end

        // R7: addresses change inside one low phase, no edge between
        for (int i = 0; i < 31; i++) begin
            @(negedge clk); #1;
            rd_addr_a = 5'(i); rd_addr_b = 5'(30 - i);
            #1;
            check("R7 comb read A first", rd_data_a, model[i]);
            check("R7 comb read B first", rd_data_b, model[30 - i]);
            rd_addr_a = 5'(30 - i); rd_addr_b = 5'(i);
            #1;
            check("R7 comb read A second", rd_data_a, model[30 - i]);
            check("R7 comb read B second", rd_data_b, model[i]);
        end

        // R8: reset mid-run beats a concurrent write
        do_reset();
        sweep("R8 reset after use");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule